// File: doc/BRIEF.md
# Clocked Synchronous Serial Shift Interface

This block is the clock-driving side of a byte-wide synchronous serial link. On one start request it sends a byte out on a transmit data line and takes in a byte from a receive data line at the same time. It also produces the serial clock that frames the transfer. The serial clock runs at a fixed fraction of the system (oscillator) clock: one serial period lasts eight system cycles, with four cycles low and four cycles high.

Bits move least significant first. The block samples each receive bit on the serial clock rising edge. It holds each transmit bit for two system cycles after that rising edge and only then moves to the next bit, so the attached device sees each new bit settle six system cycles before its next rising edge. A done flag reports the end of the transfer together with the received byte. The flag remains set until the core loads the next byte.

Top module: `sio_shift_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sclk_o and txd_o are 1, and busy_o, done_o and rx_byte_o are 0.
- R2: A start_i seen at a clock edge while busy_o is 0 is accepted. After that edge busy_o is 1, done_o is 0, sclk_o is 0 and txd_o carries bit 0 of tx_byte_i.
- R3: During a transfer sclk_o repeats a pattern of 4 cycles low followed by 4 cycles high (8 system cycles per period). Each transfer has exactly 8 rising edges, and sclk_o is 1 whenever busy_o is 0.
- R4: txd_o sends the loaded byte least significant bit first. Bit i+1 replaces bit i exactly 2 cycles after the rising edge that ends bit i, so it is visible from the 3rd cycle sclk_o is high. txd_o never changes during a transfer except while sclk_o is high.
- R5: rxd_i is sampled only at the clock edge where sclk_o rises. The first sample goes to bit 0 of rx_byte_o (least significant first). rxd_i values at any other time have no effect.
- R6: The clock edge that makes the 8th rise of sclk_o also clears busy_o, sets done_o and puts the received byte on rx_byte_o. After that, sclk_o stays 1 and txd_o keeps bit 7.
- R7: A start_i seen while busy_o is 1 is ignored, and this includes the cycle whose edge completes the transfer. The clock pattern, the transmit bits and the completion timing all stay as they were.
- R8: done_o stays 1 until the next start is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to load tx_byte_i and begin a transfer |
| tx_byte_i | input | DATA_W | Byte to transmit, captured at acceptance |
| rxd_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Serial clock, idles high |
| txd_o | output | 1 | Serial transmit data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, received byte valid |
| rx_byte_o | output | DATA_W | Last received byte |

## Verification
Completion of a transfer and a new start request can land in the same cycle. The bench provokes this by raising start_i, with a different byte, in the cycle whose edge makes the eighth rising edge. The request must be ignored: busy_o falls, done_o rises, sclk_o stays high and no second clock burst follows. The bench also holds start_i high with a different byte across half a transfer, and it changes rxd_i to random values in every cycle except the sampling edges. This shows that neither disturbance reaches txd_o or rx_byte_o.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Per-cycle events derived from the bit/phase position of a transfer.
  typedef struct packed {
    logic rise;   // serial clock goes high at this edge, sample receive bit
    logic shift;  // transmit line advances to the next bit at this edge
    logic fall;   // serial clock goes low at this edge
    logic last;   // rising edge of the final bit, transfer ends
  } sio_evt_t;
endpackage

// File: rtl/sio_phase_gen.sv
module sio_phase_gen
  import sio_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int HOLD_CYC = 2,
  parameter int NBITS    = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     run,
  output sio_evt_t ev
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PH_W-1:0]  RISE_PH  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  SHIFT_PH = PH_W'(HALF - 1 + HOLD_CYC);
  localparam logic [PH_W-1:0]  END_PH   = PH_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      ph_q  <= '0;
      bit_q <= '0;
    end else if (run) begin
      if (ph_q == END_PH) begin
        ph_q  <= '0;
        bit_q <= bit_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  always_comb begin
    ev.rise  = run && (ph_q == RISE_PH);
    ev.last  = ev.rise && (bit_q == LAST_BIT);
    ev.shift = run && (ph_q == SHIFT_PH) && (bit_q != LAST_BIT);
    ev.fall  = run && (ph_q == END_PH);
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_byte,
  input  sio_evt_t          ev,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rxd, rx_sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      txd   <= 1'b1;
    end else if (load) begin
      tx_sr <= tx_byte;
      txd   <= tx_byte[0];
    end else if (ev.shift) begin
      tx_sr <= tx_sr >> 1;
      txd   <= tx_sr[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr   <= '0;
      rx_byte <= '0;
    end else begin
      if (ev.rise) rx_sr <= rx_next;
      if (ev.last) rx_byte <= rx_next;
    end
  end
endmodule

// File: rtl/sio_shift_if.sv
module sio_shift_if
  import sio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CLK_DIV  = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              rxd_i,
  output logic              sclk_o,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  sio_evt_t ev;
  logic     load;

  // Start is honoured only when idle (R7).
  assign load = start_i && !busy_o;

  sio_phase_gen #(
    .CLK_DIV (CLK_DIV),
    .HOLD_CYC(HOLD_CYC),
    .NBITS   (DATA_W)
  ) phase_i (
    .clk (clk),
    .rst (rst),
    .load(load),
    .run (busy_o),
    .ev  (ev)
  );

  sio_shifter #(
    .DATA_W(DATA_W)
  ) shift_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .tx_byte(tx_byte_i),
    .ev     (ev),
    .rxd    (rxd_i),
    .txd    (txd_o),
    .rx_byte(rx_byte_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sclk_o <= 1'b1;
    end else if (load) begin
      busy_o <= 1'b1;
      done_o <= 1'b0;
      sclk_o <= 1'b0;
    end else begin
      if (ev.last) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
      if (ev.rise)      sclk_o <= 1'b1;
      else if (ev.fall) sclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_shift_if_chk.sv
module sio_shift_if_chk #(
  parameter int CLK_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic sclk_o,
  input logic txd_o,
  input logic busy_o,
  input logic done_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV + 1) + 1;

  logic [CW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || sclk_o) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o && !sclk_o && !done_o);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> sclk_o);

  // R3
  low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> low_run == CW'(HALF));

  // R4
  txd_window_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy_o) && !$stable(txd_o) |-> sclk_o && $past(sclk_o));

  // R6
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !busy_o && $past(busy_o) && sclk_o);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o);
endmodule

bind sio_shift_if sio_shift_if_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .sclk_o (sclk_o),
  .txd_o  (txd_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/sio_shift_if_tb_top.sv
module sio_shift_if_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       rxd_i = 1'b0;
  logic       sclk_o, txd_o, busy_o, done_o;
  logic [7:0] rx_byte_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sio_shift_if dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tx_byte_i(tx_byte_i),
    .rxd_i(rxd_i), .sclk_o(sclk_o), .txd_o(txd_o), .busy_o(busy_o),
    .done_o(done_o), .rx_byte_o(rx_byte_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Expected serial clock level at sample k after acceptance (R3).
  function automatic logic exp_sclk(input int k);
    return (k >= 61) ? 1'b1 : (((k - 1) % 8) >= 4);
  endfunction

  // Index of the bit on txd at sample k (R4): bit i shows from 8i-1.
  function automatic int exp_bit(input int k);
    return (k + 1) / 8;
  endfunction

  // mode 0: single start pulse; 1: start held during busy; 2: start at completion edge
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input int mode);
    @(negedge clk);
    start_i   = 1'b1;
    tx_byte_i = tx;
    for (int k = 1; k <= 61; k++) begin
      @(negedge clk);
      chk("R3 sclk", sclk_o, exp_sclk(k));
      chk("R4 txd", txd_o, tx[exp_bit(k)]);
      if (k < 61) begin
        chk("R2 busy", busy_o, 1'b1);
        chk("R8 done cleared by load", done_o, 1'b0);
      end else begin
        chk("R6 busy end", busy_o, 1'b0);
        chk("R6 done set", done_o, 1'b1);
        chk("R5 rx byte", rx_byte_o, rx);
        if (mode == 2) chk("R7 start at completion ignored", busy_o, 1'b0);
      end
      if (mode == 1 && k == 40) chk("R7 start while busy ignored", busy_o, 1'b1);
      // start/tx_byte stimulus
      if (mode == 1 && k < 40) begin
        start_i = 1'b1; tx_byte_i = ~tx;
      end else if (mode == 2 && k == 60) begin
        start_i = 1'b1; tx_byte_i = ~tx;
      end else begin
        start_i = 1'b0;
      end
      // rxd valid only for the coming sample edge, noise elsewhere (R5)
      if (k < 61) begin
        if (((k - 1) % 8) == 3) rxd_i = rx[(k - 1) / 8];
        else                    rxd_i = 1'($urandom);
      end
    end
    for (int j = 0; j < 3; j++) begin
      rxd_i = 1'($urandom);
      @(negedge clk);
      chk("R6 idle sclk high", sclk_o, 1'b1);
      chk("R6 txd keeps bit7", txd_o, tx[7]);
      chk("R8 done holds", done_o, 1'b1);
      chk("R7 no restart", busy_o, 1'b0);
      chk("R5 rx stable", rx_byte_o, rx);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 sclk in reset", sclk_o, 1'b1);
    chk("R1 busy in reset", busy_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sclk", sclk_o, 1'b1);
    chk("R1 txd", txd_o, 1'b1);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 rx", rx_byte_o, 8'h00);
    // directed corner patterns
    xfer(8'h01, 8'h80, 0);
    xfer(8'h80, 8'h01, 0);
    xfer(8'hA5, 8'h5A, 1);
    xfer(8'h00, 8'hFF, 2);
    xfer(8'hFF, 8'h00, 2);
    // random mix
    for (int t = 0; t < 24; t++) begin
      xfer(8'($urandom), 8'($urandom), int'($urandom % 3));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R0 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule